// File: doc/BRIEF.md
# Flash Status Register Write Guard

This block holds the 16-bit status word of a serial NOR flash device and decides whether a status write may change it. It takes opcodes that an upstream serial front end has already framed, one per clock. Four opcodes are decoded: set write enable, write status, suspend and resume. Two protect-mode bits choose how status writes are guarded:
- freely after write enable,
- gated by an active-low write-protect pin,
- locked until the next power cycle,
- locked for good.

Alongside the status word, the block keeps a suspend flag and a small set of one-time-settable lock bits for the security regions. A separate power-cycle strobe models a supply drop and return. The strobe clears the volatile state and keeps the non-volatile fields, with one exception: it releases the "locked until power cycle" mode. The reset input models the factory-fresh state of every bit.

Top module: `nor_sr_guard`

## Requirements
- R1: After reset, the status word, the write-enable output, both write result strobes and every security read-only flag are 0.
- R2: Opcode 0x06 sets the write-enable latch, which appears on `wel` and at status bit 1 on the next cycle.
- R3: In protect mode 00 (status bits 8,7 = 0,0), a status write (opcode 0x01) with the latch set is accepted whatever the level of `wp_n`. Without the latch it is refused. Each attempt gives exactly one of `wr_accept` or `wr_reject`, for one cycle after the opcode.
- R4: In protect mode 01, a status write is refused while `wp_n` is low. While `wp_n` is high it is accepted when the latch is set.
- R5: In protect mode 10, every status write is refused. A power cycle returns bits 8,7 to 0,0 and keeps the other non-volatile fields.
- R6: In protect mode 11, every status write is refused, and the mode survives power cycles.
- R7: The write-enable latch is 0 in the cycle after any status write attempt, whether the attempt was accepted or refused.
- R8: Opcode 0x75 sets the suspend flag at status bit 15. Opcode 0x7A clears it, and so does a power cycle. A status write never changes it.
- R9: The security lock bits at status bits 11, 12 and 13 can each be set on its own by an accepted write. Neither a written 0 nor a power cycle clears a set bit. `sec_ro[i]` equals lock bit 11+i.
- R10: An accepted write loads bits 2–6, 9 and 14 from the data. Bits 0, 1, 10 and 15 ignore the written data, and bits 0 and 10 always read 0.
- R11: A power cycle in the same cycle as an opcode wins. The opcode has no effect and produces no result strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset to the factory state |
| pwr_cycle | input | 1 | One-cycle strobe modelling a supply drop and return |
| op_valid | input | 1 | A framed opcode is present this cycle |
| op_code | input | 8 | Opcode value |
| wr_data | input | 16 | Status value carried by a status write |
| wp_n | input | 1 | Active-low write-protect pin |
| status | output | 16 | Full status word |
| wel | output | 1 | Write-enable latch |
| wr_accept | output | 1 | Pulse: the previous status write was accepted |
| wr_reject | output | 1 | Pulse: the previous status write was refused |
| sec_ro | output | 3 | Read-only state of each security region |

## Verification
The assertions assume that each cycle carries at most one framed opcode. They also assume that `wp_n` and `wr_data` are settled at the clock edge that samples a status write, and that `rst_n` is low from time zero across at least one edge. The stimulus meets these assumptions by changing every input only on the falling clock edge and issuing opcodes one cycle at a time. It also holds reset for several cycles before the first opcode. Power-cycle strobes are single cycles. One of them is deliberately placed on top of an opcode, so that the precedence rule is exercised rather than assumed away.

// File: rtl/nor_sr_pkg.sv
package nor_sr_pkg;
   localparam int SR_W     = 16;
   localparam int B_WEL    = 1;
   localparam int B_MODE0  = 7;
   localparam int B_MODE1  = 8;
   localparam int B_LOCK0  = 11;
   localparam int B_SUSP   = 15;
   localparam int MAX_LOCK = 3;
   localparam logic [SR_W-1:0] PLAIN_MASK = 16'h427C;

   typedef enum logic [1:0] {
      PM_SOFT      = 2'b00,
      PM_PIN       = 2'b01,
      PM_UNTIL_PWR = 2'b10,
      PM_FOREVER   = 2'b11
   } prot_mode_e;

   typedef enum logic [2:0] {
      CMD_NONE,
      CMD_WREN,
      CMD_WRSR,
      CMD_SUSP,
      CMD_RESUME
   } cmd_e;
endpackage

// File: rtl/nor_sr_decode.sv
module nor_sr_decode
   import nor_sr_pkg::*;
#(
   parameter int OP_W = 8,
   parameter logic [OP_W-1:0] OP_WREN   = 'h06,
   parameter logic [OP_W-1:0] OP_WRSR   = 'h01,
   parameter logic [OP_W-1:0] OP_SUSP   = 'h75,
   parameter logic [OP_W-1:0] OP_RESUME = 'h7A
) (
   input  logic            op_valid,
   input  logic [OP_W-1:0] op_code,
   output cmd_e            cmd
);
   if (OP_W < 1) begin : g_bad_width
      $error("nor_sr_decode: OP_W must be at least 1");
   end
   if (OP_WREN == OP_WRSR || OP_WREN == OP_SUSP || OP_WREN == OP_RESUME ||
       OP_WRSR == OP_SUSP || OP_WRSR == OP_RESUME || OP_SUSP == OP_RESUME) begin : g_bad_ops
      $error("nor_sr_decode: opcode values must be distinct");
   end

   always_comb begin
      cmd = CMD_NONE;
      if (op_valid) begin
         if (op_code == OP_WREN)        cmd = CMD_WREN;
         else if (op_code == OP_WRSR)   cmd = CMD_WRSR;
         else if (op_code == OP_SUSP)   cmd = CMD_SUSP;
         else if (op_code == OP_RESUME) cmd = CMD_RESUME;
      end
   end
endmodule

// File: rtl/nor_sr_gate.sv
module nor_sr_gate
   import nor_sr_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req,
   input  logic       wel,
   input  prot_mode_e mode,
   input  logic       wp_n,
   output logic       grant
);
   logic mode_open;

   always_comb begin
      unique case (mode)
         PM_SOFT:      mode_open = 1'b1;
         PM_PIN:       mode_open = wp_n;
         PM_UNTIL_PWR: mode_open = 1'b0;
         PM_FOREVER:   mode_open = 1'b0;
         default:      mode_open = 1'b0;
      endcase
   end

   assign grant = req & wel & mode_open;

   AST_PIN_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == PM_PIN && !wp_n) |-> !grant); // R4
   AST_LOCKED_MODES: assert property (@(posedge clk) disable iff (!rst_n)
      mode[1] |-> !grant); // R5
   AST_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
      grant |-> wel); // R3
endmodule

// File: rtl/nor_sr_store.sv
module nor_sr_store
   import nor_sr_pkg::*;
#(
   parameter int NUM_LOCK        = 3,
   parameter bit ALLOW_PERMANENT = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                pwr_cycle,
   input  cmd_e                cmd,
   input  logic                grant,
   input  logic [SR_W-1:0]     wr_data,
   output logic                wr_req,
   output logic                wel_q,
   output prot_mode_e          mode_q,
   output logic [SR_W-1:0]     sr,
   output logic [NUM_LOCK-1:0] lock_q,
   output logic                ok_q,
   output logic                ng_q
);
   if (NUM_LOCK < 1 || NUM_LOCK > MAX_LOCK) begin : g_bad_lock
      $error("nor_sr_store: NUM_LOCK must be 1..3");
   end

   logic            sus_q;
   logic [SR_W-1:0] plain_q;
   logic            mode_release;
   logic            take;
   logic            unused_wr_bits;

   assign wr_req = (cmd == CMD_WRSR) && !pwr_cycle;
   assign take   = wr_req && grant;
   assign unused_wr_bits = ^{wr_data[0], wr_data[1], wr_data[10], wr_data[15]};

   if (ALLOW_PERMANENT) begin : g_perm
      assign mode_release = (mode_q == PM_UNTIL_PWR);
      AST_PERM_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
         (mode_q == PM_FOREVER) |=> (mode_q == PM_FOREVER)); // R6
   end else begin : g_noperm
      assign mode_release = mode_q[1];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wel_q   <= 1'b0;
         sus_q   <= 1'b0;
         plain_q <= '0;
         mode_q  <= PM_SOFT;
         ok_q    <= 1'b0;
         ng_q    <= 1'b0;
      end else begin
         ok_q <= take;
         ng_q <= wr_req && !grant;
         if (pwr_cycle) begin
            wel_q <= 1'b0;
            sus_q <= 1'b0;
            if (mode_release) mode_q <= PM_SOFT;
         end else begin
            unique case (cmd)
               CMD_WREN:   wel_q <= 1'b1;
               CMD_WRSR: begin
                  wel_q <= 1'b0;
                  if (grant) begin
                     plain_q <= wr_data & PLAIN_MASK;
                     mode_q  <= prot_mode_e'({wr_data[B_MODE1], wr_data[B_MODE0]});
                  end
               end
               CMD_SUSP:   sus_q <= 1'b1;
               CMD_RESUME: sus_q <= 1'b0;
               default:    ;
            endcase
         end
      end
   end

   for (genvar i = 0; i < NUM_LOCK; i++) begin : g_lock
      always_ff @(posedge clk) begin
         if (!rst_n) lock_q[i] <= 1'b0;
         else if (take && wr_data[B_LOCK0+i]) lock_q[i] <= 1'b1;
      end
   end

   always_comb begin
      sr          = plain_q;
      sr[B_WEL]   = wel_q;
      sr[B_MODE0] = mode_q[0];
      sr[B_MODE1] = mode_q[1];
      sr[B_SUSP]  = sus_q;
      for (int k = 0; k < NUM_LOCK; k++) sr[B_LOCK0+k] = lock_q[k];
   end

   AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(lock_q) & ~lock_q) == '0); // R9
   AST_WEL_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_WRSR) |=> !wel_q); // R7
   AST_SUSP_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_SUSP && !pwr_cycle) |=> sus_q); // R8
   AST_PWR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_cycle |=> (!wel_q && !sus_q && !ok_q && !ng_q)); // R11
endmodule

// File: rtl/nor_sr_guard.sv
module nor_sr_guard
   import nor_sr_pkg::*;
#(
   parameter int OP_W = 8,
   parameter int NUM_LOCK = 3,
   parameter bit ALLOW_PERMANENT = 1'b1,
   parameter logic [OP_W-1:0] OP_WREN   = 'h06,
   parameter logic [OP_W-1:0] OP_WRSR   = 'h01,
   parameter logic [OP_W-1:0] OP_SUSP   = 'h75,
   parameter logic [OP_W-1:0] OP_RESUME = 'h7A
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                pwr_cycle,
   input  logic                op_valid,
   input  logic [OP_W-1:0]     op_code,
   input  logic [15:0]         wr_data,
   input  logic                wp_n,
   output logic [15:0]         status,
   output logic                wel,
   output logic                wr_accept,
   output logic                wr_reject,
   output logic [NUM_LOCK-1:0] sec_ro
);
   cmd_e       cmd;
   logic       wr_req;
   logic       grant;
   logic       wel_q;
   prot_mode_e mode_q;

   nor_sr_decode #(
      .OP_W(OP_W), .OP_WREN(OP_WREN), .OP_WRSR(OP_WRSR),
      .OP_SUSP(OP_SUSP), .OP_RESUME(OP_RESUME)
   ) u_decode (
      .op_valid(op_valid),
      .op_code (op_code),
      .cmd     (cmd)
   );

   nor_sr_gate u_gate (
      .clk  (clk),
      .rst_n(rst_n),
      .req  (wr_req),
      .wel  (wel_q),
      .mode (mode_q),
      .wp_n (wp_n),
      .grant(grant)
   );

   nor_sr_store #(
      .NUM_LOCK(NUM_LOCK), .ALLOW_PERMANENT(ALLOW_PERMANENT)
   ) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .pwr_cycle(pwr_cycle),
      .cmd      (cmd),
      .grant    (grant),
      .wr_data  (wr_data),
      .wr_req   (wr_req),
      .wel_q    (wel_q),
      .mode_q   (mode_q),
      .sr       (status),
      .lock_q   (sec_ro),
      .ok_q     (wr_accept),
      .ng_q     (wr_reject)
   );

   assign wel = wel_q;

   AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_accept && wr_reject)); // R3
   AST_ZERO_BITS: assert property (@(posedge clk) disable iff (!rst_n)
      (status[0] == 1'b0) && (status[10] == 1'b0)); // R10
   AST_WEL_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
      status[B_WEL] == wel); // R2
endmodule

// File: tb/nor_sr_guard_tb.sv
module nor_sr_guard_tb;
   localparam int CLK_PERIOD = 10;
   localparam logic [15:0] WMASK = 16'h427C;

   typedef struct {
      logic [15:0] sr;
      logic        acc;
      logic        rej;
      logic [2:0]  ro;
      string       tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pwr_cycle = 1'b0;
   logic        op_valid = 1'b0;
   logic [7:0]  op_code = '0;
   logic [15:0] wr_data = '0;
   logic        wp_n = 1'b1;
   logic [15:0] status;
   logic        wel;
   logic        wr_accept;
   logic        wr_reject;
   logic [2:0]  sec_ro;

   int   checks = 0;
   int   errors = 0;
   logic drv_chk = 1'b0;
   exp_t exp_q[$];

   logic [15:0] m_plain = '0;
   logic [1:0]  m_mode = '0;
   logic [2:0]  m_lock = '0;
   logic        m_wel = 1'b0;
   logic        m_sus = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   nor_sr_guard u_dut (
      .clk(clk), .rst_n(rst_n), .pwr_cycle(pwr_cycle), .op_valid(op_valid),
      .op_code(op_code), .wr_data(wr_data), .wp_n(wp_n), .status(status),
      .wel(wel), .wr_accept(wr_accept), .wr_reject(wr_reject), .sec_ro(sec_ro)
   );

   task automatic step(input logic v, input logic [7:0] op, input logic [15:0] d,
                       input logic wp, input logic pw, input string tag);
      exp_t e;
      logic ok;
      @(negedge clk);
      op_valid = v; op_code = op; wr_data = d; wp_n = wp; pwr_cycle = pw;
      e.acc = 1'b0; e.rej = 1'b0;
      if (pw) begin
         m_wel = 1'b0; m_sus = 1'b0;
         if (m_mode == 2'b10) m_mode = 2'b00;
      end else if (v) begin
         case (op)
            8'h06: m_wel = 1'b1;
            8'h01: begin
               ok = m_wel && (m_mode == 2'b00 || (m_mode == 2'b01 && wp));
               if (ok) begin
                  m_plain = d & WMASK;
                  m_mode  = d[8:7];
                  m_lock  = m_lock | d[13:11];
               end
               e.acc = ok; e.rej = !ok;
               m_wel = 1'b0;
            end
            8'h75: m_sus = 1'b1;
            8'h7A: m_sus = 1'b0;
            default: ;
         endcase
      end
      e.sr = m_plain;
      e.sr[1] = m_wel;
      e.sr[8:7] = m_mode;
      e.sr[13:11] = m_lock;
      e.sr[15] = m_sus;
      e.ro = m_lock;
      e.tag = tag;
      exp_q.push_back(e);
      drv_chk = 1'b1;
   endtask

   always @(posedge clk) begin
      if (drv_chk) begin
         exp_t e;
         #1;
         if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL monitor: result with no expected item");
         end else begin
            e = exp_q.pop_front();
            checks++;
            if (status !== e.sr || wr_accept !== e.acc || wr_reject !== e.rej ||
                sec_ro !== e.ro || wel !== e.sr[1]) begin
               errors++;
               $display("FAIL %s: status=%h acc=%b rej=%b ro=%b wel=%b expected status=%h acc=%b rej=%b ro=%b",
                        e.tag, status, wr_accept, wr_reject, sec_ro, wel, e.sr, e.acc, e.rej, e.ro);
            end
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 5000);
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      step(0, 8'h00, 16'h0000, 1, 0, "R1 reset state");
      step(1, 8'h01, 16'h007C, 1, 0, "R3 write without latch refused");
      step(1, 8'h06, 16'h0000, 1, 0, "R2 write enable");
      step(1, 8'h01, 16'h8475, 0, 0, "R10 R3 mode 00 pin ignored, masked fields");
      step(1, 8'h06, 16'h0000, 1, 0, "R2 write enable");
      step(1, 8'h01, 16'h0080, 1, 0, "R3 enter pin mode");
      step(1, 8'h06, 16'h0000, 0, 0, "R2 write enable");
      step(1, 8'h01, 16'h0004, 0, 0, "R4 R7 pin low refuses and clears latch");
      step(1, 8'h06, 16'h0000, 1, 0, "R2 write enable");
      step(1, 8'h01, 16'h1880, 1, 0, "R4 R9 pin high accepts, two lock bits");
      step(1, 8'h06, 16'h0000, 1, 0, "R2 write enable");
      step(1, 8'h01, 16'h0080, 1, 0, "R9 written zero keeps lock bits");
      step(1, 8'h75, 16'h0000, 1, 0, "R8 suspend sets bit 15");
      step(1, 8'h06, 16'h0000, 1, 0, "R2 write enable");
      step(1, 8'h01, 16'h4100, 1, 0, "R8 R10 write keeps suspend, enter mode 10");
      step(1, 8'h7A, 16'h0000, 1, 0, "R8 resume clears bit 15");
      step(1, 8'h06, 16'h0000, 1, 0, "R2 write enable");
      step(1, 8'h01, 16'h0000, 1, 0, "R5 mode 10 refuses");
      step(1, 8'h75, 16'h0000, 1, 0, "R8 suspend again");
      step(1, 8'h06, 16'h0000, 1, 1, "R11 R5 power cycle beats opcode, releases mode");
      step(1, 8'h06, 16'h0000, 1, 0, "R2 write enable");
      step(1, 8'h01, 16'h6180, 1, 0, "R9 third lock bit, enter mode 11");
      step(0, 8'h00, 16'h0000, 1, 1, "R6 R9 power cycle keeps mode 11 and locks");
      step(1, 8'h06, 16'h0000, 1, 0, "R2 write enable");
      step(1, 8'h01, 16'h0000, 1, 0, "R6 mode 11 refuses");
      step(1, 8'h06, 16'h0000, 1, 0, "R2 write enable");
      step(1, 8'h01, 16'h0000, 1, 1, "R11 write under power cycle has no strobe");
      step(0, 8'h00, 16'h0000, 1, 0, "R11 idle after power cycle");
      @(negedge clk);
      op_valid = 1'b0; pwr_cycle = 1'b0; drv_chk = 1'b0;
      repeat (2) @(negedge clk);
      if (exp_q.size() != 0) begin
         errors++;
         $display("FAIL R1 scoreboard: %0d items left, expected 0", exp_q.size());
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule